// File: doc/BRIEF.md
# Multicycle 8-bit Accumulator Processor

This block is a small sequential processor that runs a fixed program held in an internal read-only program memory. The program memory is filled from a parameter when the design is elaborated. Each 16-bit instruction carries three fields. Bits 15:10 hold the opcode, bits 9:8 select a register and bits 7:0 hold an 8-bit operand. Each instruction passes through four states, one clock each, before the next one is fetched: fetch, decode, execute and write-back. Instructions never overlap. Each instruction writes at most one of the three 8-bit general registers, and only in its write-back state.

Only the load-immediate instruction (MOV) writes the register it names. Every arithmetic result goes to R1, whatever register the instruction selects as its first operand. Once the last program word has been executed, the processor raises `halted` and stays idle until reset. Debug ports show the registers and the program counter so the program can be observed from outside.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high, R1, R2, R3, the program counter and `halted` are all cleared at the next clock edge.
- R2: Every instruction occupies exactly four clocks. The registers and the program counter change only at the fourth edge after the fetch begins, and the program counter then advances by one.
- R3: Opcode 000001 (MOV) loads the operand byte into the register chosen by bits 9:8. Code 00 is R1, 01 is R2 and 10 is R3.
- R4: Opcode 000010 writes R1 with the register selected by bits 9:8 plus the register selected by operand bits 1:0, modulo 256.
- R5: Opcode 000011 writes R1 with the selected register plus the operand byte, modulo 256.
- R6: Opcode 000100 writes R1 with the selected register minus the operand byte, modulo 256. For example, 5 minus 7 gives 254.
- R7: Opcode 000101 writes R1 with the low 8 bits of the selected register times the operand byte.
- R8: Opcode 000110 writes R1 with the truncated unsigned quotient of the selected register divided by the operand byte. A divisor of zero writes 0xFF.
- R9: Opcode 000000, any opcode above 000110, and any instruction whose bits 9:8 are 11 leave every register unchanged.
- R10: After the last program word is written back, `halted` rises and stays high. The program counter and registers then hold their values until reset.
- R11: The default program 0x0504, 0x0407, 0x0801, 0x0605, 0x1207, 0x1504, 0x1803, 0x0000 ends with R1=5, R2=4 and R3=5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halted | output | 1 | High once the program has run to its end |
| dbg_pc | output | PC_W (4) | Program counter, the index of the next word to run |
| dbg_regs | output | NREGS*DW (24) | Register contents: R1 in bits 7:0, R2 in 15:8, R3 in 23:16 |

## Verification
An instruction whose fetch starts at edge n shows its result at edge n+4. The program counter steps at that same edge. `halted` rises at the commit edge of the last word, which is edge 32 after reset for an eight-word program. A behavioural model in the bench counts the same four phases and executes each word at its fourth edge. The bench compares every debug output against the model on each falling edge, half a cycle after the design updates. It also keeps a snapshot after each commit, so each arithmetic, load and ignored case can be checked against a value worked out by hand.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OPW = 6;
  localparam logic [OPW-1:0] OP_NOP  = 6'd0;
  localparam logic [OPW-1:0] OP_LDI  = 6'd1;
  localparam logic [OPW-1:0] OP_ADDR = 6'd2;
  localparam logic [OPW-1:0] OP_ADDI = 6'd3;
  localparam logic [OPW-1:0] OP_SUBI = 6'd4;
  localparam logic [OPW-1:0] OP_MULI = 6'd5;
  localparam logic [OPW-1:0] OP_DIVI = 6'd6;

  typedef enum logic [2:0] {
    ST_FETCH = 3'd0,
    ST_DEC   = 3'd1,
    ST_EXE   = 3'd2,
    ST_WB    = 3'd3,
    ST_HALT  = 3'd4
  } cpu_state_e;
endpackage

// File: rtl/acc_cpu_rom.sv
module acc_cpu_rom #(
  parameter int IW    = 16,
  parameter int DEPTH = 8,
  parameter logic [DEPTH*IW-1:0] INIT = '0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  output logic [IW-1:0] q
);
  logic [IW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = INIT[i*IW +: IW];
  end

  // registered read port, suited to block RAM
  always_ff @(posedge clk) begin
    if (rd_en) q <= mem[addr];
  end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  output logic [DW-1:0]  y,
  output logic           wr
);
  logic [2*DW-1:0] prod;
  logic [DW-1:0]   sum;
  logic [DW-1:0]   addend;
  logic            sub;

  // one adder serves add and subtract (two's complement of b)
  assign sub    = (op == OP_SUBI);
  assign addend = sub ? (~b + DW'(1)) : b;
  assign sum    = a + addend;
  assign prod   = a * b;

  always_comb begin
    y  = '0;
    wr = 1'b1;
    case (op)
      OP_LDI:                  y = b;
      OP_ADDR, OP_ADDI, OP_SUBI: y = sum;
      OP_MULI:                 y = prod[DW-1:0];
      OP_DIVI:                 y = (b == '0) ? '1 : (a / b);
      default:                 wr = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_cpu_regfile.sv
module acc_cpu_regfile #(
  parameter int DW    = 8,
  parameter int NREGS = 3,
  localparam int SW   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [SW-1:0]       wsel,
  input  logic [DW-1:0]       wdata,
  input  logic [SW-1:0]       rsel_a,
  input  logic [SW-1:0]       rsel_b,
  output logic [DW-1:0]       rdata_a,
  output logic [DW-1:0]       rdata_b,
  output logic [NREGS*DW-1:0] dump
);
  logic [DW-1:0] rf [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                          rf[g] <= '0;
      else if (we && wsel == SW'(g))    rf[g] <= wdata;
    end
    assign dump[g*DW +: DW] = rf[g];
  end

  // an unused select code reads as zero
  always_comb begin
    rdata_a = '0;
    rdata_b = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (rsel_a == SW'(i)) rdata_a = rf[i];
      if (rsel_b == SW'(i)) rdata_b = rf[i];
    end
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NREGS = 3,
  parameter int DEPTH = 8,
  parameter int IW    = 16,
  parameter logic [DEPTH*IW-1:0] PROG = {16'h0000, 16'h1803, 16'h1504, 16'h1207,
                                        16'h0605, 16'h0801, 16'h0407, 16'h0504},
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PC_W = AW + 1,
  localparam int SW   = 2
) (
  input  logic                clk,
  input  logic                rst,
  output logic                halted,
  output logic [PC_W-1:0]     dbg_pc,
  output logic [NREGS*DW-1:0] dbg_regs
);
  cpu_state_e      state;
  logic [PC_W-1:0] pc;
  logic [IW-1:0]   ir;
  logic [OPW-1:0]  op_q;
  logic [SW-1:0]   sel_q, wsel_q;
  logic [DW-1:0]   a_q, b_q, res_q;
  logic            we_q;
  logic [DW-1:0]   rd_a, rd_b, alu_y;
  logic            alu_wr;

  // instruction fields
  logic [OPW-1:0] ir_op;
  logic [SW-1:0]  ir_sel;
  logic [DW-1:0]  ir_imm;
  assign ir_op  = ir[IW-1 -: OPW];
  assign ir_sel = ir[DW +: SW];
  assign ir_imm = ir[DW-1:0];

  acc_cpu_rom #(.IW(IW), .DEPTH(DEPTH), .INIT(PROG)) u_rom (
    .clk  (clk),
    .rd_en(state == ST_FETCH),
    .addr (pc[AW-1:0]),
    .q    (ir)
  );

  acc_cpu_regfile #(.DW(DW), .NREGS(NREGS)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .we     (state == ST_WB && we_q),
    .wsel   (wsel_q),
    .wdata  (res_q),
    .rsel_a (ir_sel),
    .rsel_b (ir_imm[SW-1:0]),
    .rdata_a(rd_a),
    .rdata_b(rd_b),
    .dump   (dbg_regs)
  );

  acc_cpu_alu #(.DW(DW)) u_alu (
    .op(op_q),
    .a (a_q),
    .b (b_q),
    .y (alu_y),
    .wr(alu_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_FETCH;
      pc     <= '0;
      halted <= 1'b0;
      op_q   <= OP_NOP;
      sel_q  <= '0;
      wsel_q <= '0;
      a_q    <= '0;
      b_q    <= '0;
      res_q  <= '0;
      we_q   <= 1'b0;
    end else begin
      case (state)
        ST_FETCH: state <= ST_DEC;
        ST_DEC: begin
          op_q  <= ir_op;
          sel_q <= ir_sel;
          a_q   <= rd_a;
          b_q   <= (ir_op == OP_ADDR) ? rd_b : ir_imm;
          state <= ST_EXE;
        end
        ST_EXE: begin
          res_q  <= alu_y;
          we_q   <= alu_wr && (sel_q != 2'b11);
          wsel_q <= (op_q == OP_LDI) ? sel_q : '0;
          state  <= ST_WB;
        end
        ST_WB: begin
          pc <= pc + PC_W'(1);
          if (pc == PC_W'(DEPTH - 1)) begin
            halted <= 1'b1;
            state  <= ST_HALT;
          end else begin
            state  <= ST_FETCH;
          end
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  assign dbg_pc = pc;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NREGS = 3,
  parameter int PC_W  = 4
) (
  input logic                clk,
  input logic                rst,
  input cpu_state_e          state,
  input logic [PC_W-1:0]     pc,
  input logic [NREGS*DW-1:0] regs,
  input logic                halted
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pc == '0 && regs == '0 && !halted));

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_WB) |=> $stable(pc));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WB) |=> (pc == PC_W'($past(pc) + PC_W'(1))));

  // R2
  reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_WB) |=> $stable(regs));

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc) && $stable(regs)));
endmodule

bind acc_cpu acc_cpu_chk #(.DW(DW), .NREGS(NREGS), .PC_W(PC_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .state (state),
  .pc    (dbg_pc),
  .regs  (dbg_regs),
  .halted(halted)
);

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;
  localparam int DW = 8;
  localparam int NR = 3;
  localparam int DEPTH = 8;
  localparam int PC_W = 4;
  localparam logic [DEPTH*16-1:0] PROG_A = {16'h0000, 16'h1803, 16'h1504, 16'h1207,
                                            16'h0605, 16'h0801, 16'h0407, 16'h0504};
  // MOV R3,C8; ADD R1,R3; ADD R1,+100; MUL R1,16; DIV R1,0; MOV sel11; op 3F; MOV R2,9
  localparam logic [DEPTH*16-1:0] PROG_B = {16'h0509, 16'hFC55, 16'h0733, 16'h1800,
                                            16'h1410, 16'h0C64, 16'h0802, 16'h06C8};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [1:0]         halted;
  logic [PC_W-1:0]    pc   [2];
  logic [NR*DW-1:0]   regs [2];

  acc_cpu u_acc_cpu (.clk(clk), .rst(rst), .halted(halted[0]), .dbg_pc(pc[0]), .dbg_regs(regs[0]));
  acc_cpu #(.PROG(PROG_B)) u_acc_cpu_alt (.clk(clk), .rst(rst), .halted(halted[1]),
                                          .dbg_pc(pc[1]), .dbg_regs(regs[1]));

  int checks = 0;
  int fails  = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_r [2][3];
  int m_pc [2];
  int m_ph [2];
  bit m_halt [2];
  bit m_commit [2];
  int m_idx [2];
  logic [NR*DW-1:0] snap [2][DEPTH];

  function automatic logic [15:0] word(input int k, input int i);
    return (k == 0) ? PROG_A[i*16 +: 16] : PROG_B[i*16 +: 16];
  endfunction

  task automatic run_word(input int k, input logic [15:0] w);
    int op, sel, imm, a, b;
    op  = int'(w[15:10]);
    sel = int'(w[9:8]);
    imm = int'(w[7:0]);
    if (sel == 3) return;
    a = m_r[k][sel];
    case (op)
      1: m_r[k][sel] = imm;
      2: begin b = (imm % 4 == 3) ? 0 : m_r[k][imm % 4]; m_r[k][0] = (a + b) % 256; end
      3: m_r[k][0] = (a + imm) % 256;
      4: m_r[k][0] = (a - imm + 256) % 256;
      5: m_r[k][0] = (a * imm) % 256;
      6: m_r[k][0] = (imm == 0) ? 255 : a / imm;
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      m_commit[k] = 1'b0;
      if (rst) begin
        for (int j = 0; j < 3; j++) m_r[k][j] = 0;
        m_pc[k] = 0; m_ph[k] = 0; m_halt[k] = 1'b0;
      end else if (!m_halt[k]) begin
        m_ph[k]++;
        if (m_ph[k] == 4) begin
          run_word(k, word(k, m_pc[k]));
          m_idx[k] = m_pc[k];
          m_commit[k] = 1'b1;
          m_ph[k] = 0;
          m_pc[k]++;
          if (m_pc[k] == DEPTH) m_halt[k] = 1'b1;
        end
      end
    end
  end

  bit started = 1'b0;
  always @(negedge clk) begin
    if (started) begin
      for (int k = 0; k < 2; k++) begin
        // R2: cycle-exact comparison with the model
        check("R2 regs", 32'(regs[k]), 32'({8'(m_r[k][2]), 8'(m_r[k][1]), 8'(m_r[k][0])}));
        check("R2 pc", 32'(pc[k]), 32'(m_pc[k]));
        check("R10 halted", 32'(halted[k]), 32'(m_halt[k]));
        if (m_commit[k]) snap[k][m_idx[k]] = regs[k];
      end
    end
  end

  function automatic logic [31:0] rv(input logic [7:0] r3, input logic [7:0] r2, input logic [7:0] r1);
    return {8'h00, r3, r2, r1};
  endfunction

  initial begin : watchdog
    repeat (2000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=halted");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 regs", 32'(regs[0]), 32'h0);
    check("R1 pc", 32'(pc[0]), 32'h0);
    check("R1 halted", 32'(halted[0]), 32'h0);
    started = 1'b1;
    rst = 1'b0;
    while (halted !== 2'b11) @(negedge clk);
    repeat (12) @(negedge clk);
    // default program, intermediate and final results
    check("R3 MOV R2", 32'(snap[0][0]), rv(8'd0, 8'd4, 8'd0));
    check("R3 MOV R1", 32'(snap[0][1]), rv(8'd0, 8'd4, 8'd7));
    check("R4 ADD R1+R2", 32'(snap[0][2]), rv(8'd0, 8'd4, 8'd11));
    check("R6 SUB wrap", 32'(snap[0][4]), rv(8'd5, 8'd4, 8'd254));
    check("R7 MUL", 32'(snap[0][5]), rv(8'd5, 8'd4, 8'd16));
    check("R8 DIV", 32'(snap[0][6]), rv(8'd5, 8'd4, 8'd5));
    check("R9 NOP", 32'(snap[0][7]), rv(8'd5, 8'd4, 8'd5));
    check("R11 final", 32'(regs[0]), rv(8'd5, 8'd4, 8'd5));
    check("R10 pc end", 32'(pc[0]), 32'd8);
    // alternate program
    check("R3 MOV R3", 32'(snap[1][0]), rv(8'hC8, 8'd0, 8'd0));
    check("R4 ADD R1+R3", 32'(snap[1][1]), rv(8'hC8, 8'd0, 8'd200));
    check("R5 ADDI wrap", 32'(snap[1][2]), rv(8'hC8, 8'd0, 8'd44));
    check("R7 MUL low byte", 32'(snap[1][3]), rv(8'hC8, 8'd0, 8'd192));
    check("R8 DIV by zero", 32'(snap[1][4]), rv(8'hC8, 8'd0, 8'hFF));
    check("R9 select 11", 32'(snap[1][5]), rv(8'hC8, 8'd0, 8'hFF));
    check("R9 undefined op", 32'(snap[1][6]), rv(8'hC8, 8'd0, 8'hFF));
    check("R3 MOV R2 last", 32'(regs[1]), rv(8'hC8, 8'd9, 8'hFF));
    check("R10 halted alt", 32'(halted[1]), 32'h1);
    // R1: reset again from a halted state
    rst = 1'b1;
    @(negedge clk);
    check("R1 regs after rerun", 32'(regs[1]), 32'h0);
    check("R1 halted after rerun", 32'(halted[1]), 32'h0);
    check("R1 pc after rerun", 32'(pc[1]), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule